// File: doc/BRIEF.md
# Four-Cycle Unsigned Divider

This block divides one 16-bit unsigned operand by another and returns both the quotient and the remainder, so a processor pipeline can send its divide and its modulo operations to the same unit. It uses restoring shift-subtract division. The full division takes sixteen steps. The unit chains four steps in combinational logic and runs that chain once per clock, so every operation takes exactly four cycles, whatever the operands are.

The client raises `start_i` for one cycle while the unit is idle and presents both operands in that cycle. The unit raises `busy_o` in the next cycle. After four working cycles `busy_o` drops and `done_o` pulses for one cycle. The results then stay on the output ports until the next operation is accepted. A start request that arrives while the unit is busy is ignored. If the divisor is zero, both results are zero, and the timing is the same as for any other operation.

Top module: `fourstep_divider`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o` and `done_o` are 0 and `quotient_o` and `remainder_o` are 0 until the first start is accepted.
- R2: A start is accepted when `start_i` is 1 at a rising edge while `busy_o` is 0. In the cycle after an accepted start, `busy_o` is 1.
- R3: `done_o` is 1 for exactly one cycle, namely the fourth cycle after the cycle in which the start was accepted. During the first three of those cycles `done_o` is 0 and `busy_o` is 1. When `done_o` is 1, `busy_o` is 0.
- R4: For a nonzero divisor, `quotient_o` equals floor(dividend / divisor) when `done_o` is 1. Both operands are treated as unsigned.
- R5: For a nonzero divisor, `remainder_o` equals dividend mod divisor when `done_o` is 1, and it is less than the divisor.
- R6: For a divisor of zero, `quotient_o` and `remainder_o` are both 0 when `done_o` is 1. `done_o` still arrives with the latency given in R3.
- R7: If `start_i` is raised while `busy_o` is 1, it has no effect. The operands presented with it change neither the result nor the cycle in which `done_o` pulses.
- R8: From the `done_o` cycle until the next accepted start, `quotient_o` and `remainder_o` hold their values.
- R9: In the cycle after an accepted start, `quotient_o` and `remainder_o` are both 0.
- R10: A start raised in the same cycle as `done_o` is accepted. The results of the finishing operation are visible in that cycle, and the new operation follows the timing of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to begin a division; honoured only while idle |
| dividend_i | input | 16 | Unsigned dividend, sampled when a start is accepted |
| divisor_i | input | 16 | Unsigned divisor, sampled when a start is accepted |
| busy_o | output | 1 | High during the four working cycles |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| quotient_o | output | 16 | Unsigned quotient (zero for a zero divisor) |
| remainder_o | output | 16 | Unsigned remainder (zero for a zero divisor) |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next start. Back-to-back operations provoke this case. In the bench, the next request is driven in exactly the cycle where `done_o` is high. The finishing results are then judged in that cycle, and the new operation's busy and clear behaviour is judged in the following one. A second overlap is also provoked: a start request raised in the middle of a busy window. The bench judges it by checking that the pending result and the cycle of its `done_o` pulse stay unchanged.

// File: rtl/fsdiv_pkg.sv
package fsdiv_pkg;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_STEPS  = 4;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/fsdiv_rst_sync.sv
module fsdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fsdiv_step.sv
// One restoring shift-subtract step.
module fsdiv_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  output logic [W-1:0] num_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] shifted;
  logic         below;

  always_comb begin
    shifted = {rem_i[W-2:0], num_i[W-1]};
    below   = (shifted < den_i);
    quo_o   = {quo_i[W-2:0], ~below};
    rem_o   = below ? shifted : (shifted - den_i);
    num_o   = {num_i[W-2:0], 1'b0};
  end
endmodule

// File: rtl/fsdiv_stage.sv
// STEPS chained steps evaluated in one cycle.
module fsdiv_stage #(
  parameter int W     = 16,
  parameter int STEPS = 4
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  output logic [W-1:0] num_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] num_c [0:STEPS];
  logic [W-1:0] rem_c [0:STEPS];
  logic [W-1:0] quo_c [0:STEPS];

  assign num_c[0] = num_i;
  assign rem_c[0] = rem_i;
  assign quo_c[0] = quo_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    fsdiv_step #(.W(W)) u_step (
      .num_i (num_c[g]),
      .den_i (den_i),
      .rem_i (rem_c[g]),
      .quo_i (quo_c[g]),
      .num_o (num_c[g+1]),
      .rem_o (rem_c[g+1]),
      .quo_o (quo_c[g+1])
    );
  end

  assign num_o = num_c[STEPS];
  assign rem_o = rem_c[STEPS];
  assign quo_o = quo_c[STEPS];
endmodule

// File: rtl/fsdiv_ctrl.sv
// Sequencer: accepts a start when idle, counts CYCLES working cycles.
module fsdiv_ctrl
  import fsdiv_pkg::*;
#(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLES - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    load_o  = (phase_q == PH_IDLE) && start_i;
    step_o  = (phase_q == PH_RUN);
    last_o  = step_o && (cnt_q == LAST_CNT);
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = last_o;
    cnt_en  = load_o || step_o;
    if (load_o) begin
      phase_d = PH_RUN;
      cnt_d   = '0;
    end else if (step_o) begin
      cnt_d = cnt_q + 1'b1;
      if (last_o) phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (cnt_en) begin
        phase_q <= phase_d;
        cnt_q   <= cnt_d;
      end
    end
  end

  assign busy_o = (phase_q == PH_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/fourstep_divider.sv
module fourstep_divider
  import fsdiv_pkg::*;
#(
  parameter int DATA_W        = DEF_DATA_W,
  parameter int STEPS_PER_CYC = DEF_STEPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] quotient_o,
  output logic [DATA_W-1:0] remainder_o
);
  localparam int CYCLES = DATA_W / STEPS_PER_CYC;

  logic              rst_n_i;
  logic              load, step, last;
  logic [DATA_W-1:0] num_q, num_d, den_q, den_d, rem_q, rem_d, quo_q, quo_d;
  logic              zero_q, zero_d;
  logic [DATA_W-1:0] num_s, rem_s, quo_s;
  logic              dp_en;

  fsdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  fsdiv_ctrl #(.CYCLES(CYCLES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  fsdiv_stage #(.W(DATA_W), .STEPS(STEPS_PER_CYC)) u_stage (
    .num_i (num_q),
    .den_i (den_q),
    .rem_i (rem_q),
    .quo_i (quo_q),
    .num_o (num_s),
    .rem_o (rem_s),
    .quo_o (quo_s)
  );

  // next-state
  always_comb begin
    num_d  = num_q;
    den_d  = den_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    zero_d = zero_q;
    dp_en  = load || step;
    if (load) begin
      num_d  = dividend_i;
      den_d  = divisor_i;
      rem_d  = '0;
      quo_d  = '0;
      zero_d = (divisor_i == '0);
    end else if (step) begin
      num_d = num_s;
      rem_d = rem_s;
      quo_d = quo_s;
      if (last && zero_q) begin
        rem_d = '0;
        quo_d = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      zero_q <= 1'b0;
    end else if (dp_en) begin
      num_q  <= num_d;
      den_q  <= den_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      zero_q <= zero_d;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
endmodule

// File: rtl/fsdiv_checker.sv
module fsdiv_checker #(
  parameter int DATA_W = 16,
  parameter int CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] dividend_i,
  input logic [DATA_W-1:0] divisor_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] quotient_o,
  input logic [DATA_W-1:0] remainder_o
);
  localparam int AW = $clog2(CYCLES + 2) + 1;
  localparam logic [AW-1:0] DONE_AGE = AW'(CYCLES + 1);

  logic              accept;
  logic [AW-1:0]     age_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [2*DATA_W-1:0] recon;

  assign accept = start_i && !busy_o;
  assign recon  = ({{DATA_W{1'b0}}, quotient_o} * {{DATA_W{1'b0}}, b_q})
                + {{DATA_W{1'b0}}, remainder_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (accept) begin
      age_q <= AW'(1);
      a_q   <= dividend_i;
      b_q   <= divisor_i;
    end else if (age_q != '0 && age_q != DONE_AGE) begin
      age_q <= age_q + 1'b1;
    end
  end

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (age_q == DONE_AGE));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && b_q != '0) |-> (recon == {{DATA_W{1'b0}}, a_q}));

  assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && b_q != '0) |-> (remainder_o < b_q));

  assert_zero_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && b_q == '0) |-> (quotient_o == '0 && remainder_o == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (quotient_o == '0 && remainder_o == '0));
endmodule

bind fourstep_divider fsdiv_checker #(.DATA_W(DATA_W), .CYCLES(CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o)
);

// File: tb/fourstep_divider_bench.sv
module fourstep_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] dividend_i = '0;
  logic [15:0] divisor_i = '0;
  logic        busy_o, done_o;
  logic [15:0] quotient_o, remainder_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fourstep_divider u_fourstep_divider (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o)
  );

  function automatic logic [15:0] ref_q(input logic [15:0] a, input logic [15:0] b);
    return (b == 16'd0) ? 16'd0 : a / b;
  endfunction

  function automatic logic [15:0] ref_r(input logic [15:0] a, input logic [15:0] b);
    return (b == 16'd0) ? 16'd0 : a % b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // At a negedge: present operands, let the start be sampled, check R2/R9.
  task automatic launch(input logic [15:0] a, input logic [15:0] b);
    start_i = 1'b1; dividend_i = a; divisor_i = b;
    tick();
    start_i = 1'b0; dividend_i = ~a; divisor_i = ~b;
    check("R2 busy after start", {31'd0, busy_o}, 32'd1);
    check("R9 quotient cleared", {16'd0, quotient_o}, 32'd0);
    check("R9 remainder cleared", {16'd0, remainder_o}, 32'd0);
  endtask

  // Runs the remaining working cycles; ends in the done cycle.
  task automatic await_done(input logic [15:0] a, input logic [15:0] b, input bit poke);
    for (int i = 1; i <= 3; i++) begin
      if (poke && i == 2) begin
        start_i = 1'b1; dividend_i = 16'hFFFF; divisor_i = 16'd1;  // R7 ignored start
      end
      tick();
      start_i = 1'b0;
      check("R3 no early done", {31'd0, done_o}, 32'd0);
      check("R3 busy during run", {31'd0, busy_o}, 32'd1);
    end
    tick();
    check("R3 done on fourth cycle", {31'd0, done_o}, 32'd1);
    check("R3 idle at done", {31'd0, busy_o}, 32'd0);
    if (b == 16'd0) begin
      check("R6 zero-divisor quotient", {16'd0, quotient_o}, 32'd0);
      check("R6 zero-divisor remainder", {16'd0, remainder_o}, 32'd0);
    end else begin
      check(poke ? "R7 R4 quotient" : "R4 quotient", {16'd0, quotient_o}, {16'd0, ref_q(a, b)});
      check(poke ? "R7 R5 remainder" : "R5 remainder", {16'd0, remainder_o}, {16'd0, ref_r(a, b)});
    end
  endtask

  task automatic one_op(input logic [15:0] a, input logic [15:0] b, input bit poke);
    launch(a, b);
    await_done(a, b, poke);
    tick();
    check("R3 done single pulse", {31'd0, done_o}, 32'd0);
    check("R8 quotient held", {16'd0, quotient_o}, {16'd0, ref_q(a, b)});
    check("R8 remainder held", {16'd0, remainder_o}, {16'd0, ref_r(a, b)});
    repeat (2) tick();
    check("R8 quotient held later", {16'd0, quotient_o}, {16'd0, ref_q(a, b)});
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] seed;
    logic [15:0] ra, rb;
    seed = $urandom(32'd20250417);
    @(negedge clk);
    tick();
    check("R1 busy in reset", {31'd0, busy_o}, 32'd0);
    check("R1 done in reset", {31'd0, done_o}, 32'd0);
    check("R1 quotient in reset", {16'd0, quotient_o}, 32'd0);
    check("R1 remainder in reset", {16'd0, remainder_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 busy after reset", {31'd0, busy_o}, 32'd0);
    check("R1 quotient after reset", {16'd0, quotient_o}, 32'd0);

    // directed corners
    one_op(16'd100, 16'd7, 0);
    one_op(16'hFFFF, 16'hFFFF, 0);
    one_op(16'hFFFF, 16'd1, 0);
    one_op(16'h1234, 16'd0, 0);     // R6
    one_op(16'd0, 16'd0, 0);        // R6
    one_op(16'd5, 16'd9, 0);
    one_op(16'hFFFE, 16'hFFFF, 0);
    one_op(16'd0, 16'd3, 0);
    one_op(16'd1000, 16'd33, 1);    // R7 start while busy

    // R10 back-to-back: next start in the done cycle
    launch(16'd50000, 16'd123);
    await_done(16'd50000, 16'd123, 0);
    launch(16'd777, 16'd0);
    check("R10 second op busy", {31'd0, busy_o}, 32'd1);
    await_done(16'd777, 16'd0, 0);
    launch(16'd4321, 16'd10);
    await_done(16'd4321, 16'd10, 0);
    tick();

    // constrained random
    for (int n = 0; n < 60; n++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      case (n % 4)
        1: rb = rb & 16'h00FF;
        2: rb = (n % 8 == 2) ? 16'd0 : rb;
        3: ra = 16'hFFFF;
        default: ;
      endcase
      one_op(ra, rb, (n % 5 == 0));
    end
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule